// File: doc/BRIEF.md
# Two-by-Two Wormhole Routing Switch

This block is one switching element of a multistage network that connects processor clusters. It has two input links and two output links. Each link is unidirectional and nine bits wide, with a valid/ready handshake. Every input has its own small FIFO in front of a crossbar. A message is a header flit, then a byte-count flit, then that many payload flits. The element reads one bit of the destination byte in the header and uses that bit to choose an output. Once the header has won the output, the path stays reserved for that message until its last flit has left.

A flit is an 8-bit data byte in bits 7:0, plus a marker in bit 8 that is set only on headers. Which address bit a given element decodes is a parameter, so that every stage of the network can use the same code. When both inputs want the same free output at once, a round-robin choice decides. The losing header waits at the head of its FIFO. The switch never drops a flit: an output that is not accepted holds its flit until downstream takes it.

Top module: `wh_switch2x2`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both `out_valid` bits are low and both `in_ready` bits are high.
- R2: An input takes a flit on each clock edge where its `in_valid` and `in_ready` are both high. `in_ready` drops once that input's 8-entry FIFO holds 8 flits, so with the output blocked exactly 8 flits are taken. Flits leave an input in the order they arrived.
- R3: A flit with bit 8 set is a header. Bit ROUTE_BIT of its data byte selects the output: 0 selects output 0 and 1 selects output 1. Headers leave only on the output they select.
- R4: The second flit of a message carries the payload count in bits 7:0. The message ends after that many payload flits. A count above MAX_PAYLOAD (128) is treated as 128.
- R5: A flit with bit 8 clear that arrives where a header is expected is discarded and never appears on an output. The following message is unaffected.
- R6: Once an output carries a header, it carries only the flits of that message, unchanged and in order, up to and including its tail. Two messages are never interleaved.
- R7: Two inputs that target different outputs are forwarded at the same time. If both headers are accepted on the same edge, both appear on the same cycle.
- R8: When both inputs present headers for the same free output in the same cycle, the input that did not most recently hold that output wins. After reset, input 0 wins the first contest. The loser keeps its header and is served after the winner's tail.
- R9: While `out_valid` is high and `out_ready` is low, the output keeps `out_valid` high and `out_flit` unchanged.
- R10: A header accepted on clock edge k, at an idle switch, is presented with `out_valid` high from edge k+2 on.
- R11: The output is freed on the edge that transfers a tail. The next header on that output appears no earlier than two edges after that edge, and exactly two edges after it when a header is already waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 2 | Flit offered on each input link |
| in_flit | input | 2x9 | Flit on each input link: marker in bit 8, byte in bits 7:0 |
| in_ready | output | 2 | Input FIFO has room for a flit |
| out_valid | output | 2 | Flit offered on each output link |
| out_flit | output | 2x9 | Flit on each output link |
| out_ready | input | 2 | Downstream accepts the offered flit |

## Verification
A header is due on its output two edges after the edge that accepted it: one edge writes the FIFO and one edge registers the grant. The next header on a freed output is due two edges after the tail's transfer edge. The bench stamps each driven header and each observed output flit with a cycle count taken at the rising edge, and compares the difference with these delays. Every output sample is taken just after the falling edge, once the bench has set that cycle's `out_ready`, so the flit that is sampled is exactly the one transferred on the following edge. Flit order, routing and payload counts are checked against per-source, per-destination queues that the bench builds from the message parameters.

// File: rtl/wh_pkg.sv
package wh_pkg;

  localparam int NPORT    = 2;
  localparam int BYTE_W   = 8;
  localparam int FLIT_W   = BYTE_W + 1;
  localparam int MARK_POS = BYTE_W;

  typedef logic [FLIT_W-1:0] flit_t;

  typedef enum logic [1:0] {
    RX_HEAD  = 2'd0,
    RX_COUNT = 2'd1,
    RX_BODY  = 2'd2
  } rx_phase_e;

  // header marker
  function automatic logic is_marked(input flit_t f);
    return f[MARK_POS];
  endfunction

  // output selected by one destination bit
  function automatic logic pick_port(input logic [BYTE_W-1:0] addr,
                                     input logic [2:0] idx);
    return addr[idx];
  endfunction

  // payload count limited to the largest legal message
  function automatic logic [BYTE_W-1:0] clamp_count(input logic [BYTE_W-1:0] raw,
                                                    input logic [BYTE_W-1:0] cap);
    return (raw > cap) ? cap : raw;
  endfunction

endpackage

// File: rtl/wh_fifo.sv
module wh_fifo
  import wh_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push_valid,
  input  flit_t push_flit,
  output logic  push_ready,
  input  logic  pop,
  output logic  head_valid,
  output flit_t head_flit
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  flit_t          mem [DEPTH];
  logic [AW-1:0]  wp;
  logic [AW-1:0]  rp;
  logic [CW-1:0]  fill;
  logic           do_push;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ready = (fill != CW'(DEPTH));
  assign do_push    = push_valid && push_ready;
  assign head_valid = (fill != '0);
  assign head_flit  = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (pop)     rp <= step(rp);
      case ({do_push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_flit;
  end

  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_valid);

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_ready && !pop) |=> !push_ready);

endmodule

// File: rtl/wh_rx_track.sv
module wh_rx_track
  import wh_pkg::*;
#(
  parameter int ROUTE_BIT   = 0,
  parameter int MAX_PAYLOAD = 128
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  head_valid,
  input  flit_t head_flit,
  input  logic  pop,
  output logic  want,
  output logic  want_port,
  output logic  discard,
  output logic  at_header,
  output logic  at_tail
);

  localparam logic [2:0]        RB  = 3'(ROUTE_BIT);
  localparam logic [BYTE_W-1:0] CAP = BYTE_W'(MAX_PAYLOAD);

  rx_phase_e          phase;
  logic [BYTE_W-1:0]  left;
  logic [BYTE_W-1:0]  head_byte;
  logic [BYTE_W-1:0]  body_len;

  assign head_byte = head_flit[BYTE_W-1:0];
  assign body_len  = clamp_count(head_byte, CAP);
  assign at_header = head_valid && (phase == RX_HEAD) && is_marked(head_flit);
  assign discard   = head_valid && (phase == RX_HEAD) && !is_marked(head_flit);
  assign want      = at_header;
  assign want_port = pick_port(head_byte, RB);
  assign at_tail   = head_valid &&
                     (((phase == RX_COUNT) && (body_len == '0)) ||
                      ((phase == RX_BODY) && (left == BYTE_W'(1))));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= RX_HEAD;
      left  <= '0;
    end else if (pop) begin
      case (phase)
        RX_HEAD: begin
          if (is_marked(head_flit)) phase <= RX_COUNT;
        end
        RX_COUNT: begin
          left  <= body_len;
          phase <= (body_len == '0) ? RX_HEAD : RX_BODY;
        end
        RX_BODY: begin
          left <= left - 1'b1;
          if (left == BYTE_W'(1)) phase <= RX_HEAD;
        end
        default: phase <= RX_HEAD;
      endcase
    end
  end

  // R4
  body_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == RX_BODY) |-> (left != '0));

  // R5
  discard_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && discard) |=> (phase == RX_HEAD));

endmodule

// File: rtl/wh_out_alloc.sv
module wh_out_alloc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic       tail_xfer,
  output logic       bound,
  output logic       owner
);

  logic       last_q;
  logic       win;
  logic [1:0] grant;

  always_comb begin
    win   = (req == 2'b11) ? ~last_q : req[1];
    grant = 2'b00;
    if (!bound && (req != 2'b00)) grant[win] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bound  <= 1'b0;
      owner  <= 1'b0;
      last_q <= 1'b1;
    end else if (grant != 2'b00) begin
      bound  <= 1'b1;
      owner  <= win;
      last_q <= win;
    end else if (tail_xfer) begin
      bound <= 1'b0;
    end
  end

  // R11
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tail_xfer |=> !bound);

  // R6
  bind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bound && !tail_xfer) |=> (bound && $stable(owner)));

  // R8
  contest_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bound && (req == 2'b11)) |=> (bound && (owner != $past(last_q))));

endmodule

// File: rtl/wh_switch2x2.sv
module wh_switch2x2
  import wh_pkg::*;
#(
  parameter int ROUTE_BIT   = 0,
  parameter int FIFO_DEPTH  = 8,
  parameter int MAX_PAYLOAD = 128
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORT-1:0]              in_valid,
  input  logic [NPORT-1:0][FLIT_W-1:0]  in_flit,
  output logic [NPORT-1:0]              in_ready,
  output logic [NPORT-1:0]              out_valid,
  output logic [NPORT-1:0][FLIT_W-1:0]  out_flit,
  input  logic [NPORT-1:0]              out_ready
);

  localparam int RB = ROUTE_BIT;

  flit_t                       hd_flit [NPORT];
  logic [NPORT-1:0]            hd_valid;
  logic [NPORT-1:0]            pop;
  logic [NPORT-1:0]            want;
  logic [NPORT-1:0]            want_port;
  logic [NPORT-1:0]            discard;
  logic [NPORT-1:0]            at_header;
  logic [NPORT-1:0]            at_tail;
  logic [NPORT-1:0]            bound;
  logic [NPORT-1:0]            owner;
  logic [NPORT-1:0]            tail_xfer;
  logic [NPORT-1:0]            linked;
  logic [NPORT-1:0]            link_port;
  logic [NPORT-1:0][NPORT-1:0] req;

  // which output, if any, each input currently owns
  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      linked[i]    = 1'b0;
      link_port[i] = 1'b0;
      for (int o = 0; o < NPORT; o++) begin
        if (bound[o] && (owner[o] == 1'(i))) begin
          linked[i]    = 1'b1;
          link_port[i] = 1'(o);
        end
      end
    end
  end

  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      for (int i = 0; i < NPORT; i++) begin
        req[o][i] = want[i] && (want_port[i] == 1'(o)) && !linked[i];
      end
    end
  end

  genvar g;
  for (g = 0; g < NPORT; g++) begin : g_lane

    wh_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (in_valid[g]),
      .push_flit  (in_flit[g]),
      .push_ready (in_ready[g]),
      .pop        (pop[g]),
      .head_valid (hd_valid[g]),
      .head_flit  (hd_flit[g])
    );

    wh_rx_track #(.ROUTE_BIT(ROUTE_BIT), .MAX_PAYLOAD(MAX_PAYLOAD)) i_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .head_valid (hd_valid[g]),
      .head_flit  (hd_flit[g]),
      .pop        (pop[g]),
      .want       (want[g]),
      .want_port  (want_port[g]),
      .discard    (discard[g]),
      .at_header  (at_header[g]),
      .at_tail    (at_tail[g])
    );

    wh_out_alloc i_alloc (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req[g]),
      .tail_xfer (tail_xfer[g]),
      .bound     (bound[g]),
      .owner     (owner[g])
    );

    assign out_valid[g] = bound[g] && hd_valid[owner[g]];
    assign out_flit[g]  = hd_flit[owner[g]];
    assign tail_xfer[g] = out_valid[g] && out_ready[g] && at_tail[owner[g]];
    assign pop[g]       = (linked[g] && hd_valid[g] && out_ready[link_port[g]]) ||
                          discard[g];

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[g] && !out_ready[g]) |=> (out_valid[g] && $stable(out_flit[g])));

    // R3
    route_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[g] && at_header[owner[g]]) |-> (out_flit[g][RB] == 1'(g)));

  end

endmodule

// File: tb/test_wh_switch2x2.sv
`timescale 1ns/1ps
module test_wh_switch2x2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic            v0, v1;
  logic [8:0]      f0, f1;
  logic [1:0]      in_valid;
  logic [1:0][8:0] in_flit;
  logic [1:0]      in_ready;
  logic [1:0]      out_valid;
  logic [1:0][8:0] out_flit;
  logic [1:0]      out_ready;

  assign in_valid = {v1, v0};
  assign in_flit  = {f1, f0};

  wh_switch2x2 i_wh_switch2x2 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_flit   (in_flit),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_flit  (out_flit),
    .out_ready (out_ready)
  );

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [8:0] srcq0 [$];
  logic [8:0] srcq1 [$];
  logic [8:0] expq [4][$];
  int         hlog [2][$];
  int         acc0, acc1;
  int         drv_hdr_cyc [2];
  bit         stall, bp;
  logic [15:0] lfsr;

  int         mphase [2];
  int         cur [2];
  int         rem [2];
  int         out_hdr_cyc [2];
  int         last_tail_cyc [2];
  int         last_gap [2];
  int         last_len [2];
  bit         held [2];
  logic [8:0] held_flit [2];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pending();
    int n;
    n = srcq0.size() + srcq1.size() + int'(v0) + int'(v1);
    for (int k = 0; k < 4; k++) n += expq[k].size();
    return n;
  endfunction

  // message: header {1, src, seq[5:0], route}, count flit, clamped payload
  task automatic send(input int s, input int route, input int len, input int seq);
    logic [8:0] fl;
    int n;
    n = (len > 128) ? 128 : len;
    for (int j = 0; j < n + 2; j++) begin
      if (j == 0)      fl = {1'b1, 1'(s), 6'(seq), 1'(route)};
      else if (j == 1) fl = {1'b0, 8'(len)};
      else             fl = {1'b0, 8'(seq * 37 + j * 11 + s)};
      if (s == 0) srcq0.push_back(fl); else srcq1.push_back(fl);
      expq[s * 2 + route].push_back(fl);
    end
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while (pending() != 0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
    check(pending() == 0, "R6 all expected flits delivered", pending(), 0);
  endtask

  task automatic compare(input int o, input logic [8:0] fl);
    logic [8:0] e;
    if (expq[cur[o]].size() == 0) begin
      check(1'b0, "R6 unexpected flit", int'(fl), 0);
    end else begin
      e = expq[cur[o]].pop_front();
      check(fl == e, "R6 flit content/order", int'(fl), int'(e));
    end
  endtask

  task automatic consume(input int o, input logic [8:0] fl);
    int s;
    if (mphase[o] == 0) begin
      if (!fl[8]) begin
        check(1'b0, "R5 unmarked flit where header due", int'(fl), 0);
      end else begin
        s = int'(fl[7]);
        cur[o] = s * 2 + o;
        hlog[o].push_back(s);
        out_hdr_cyc[o] = cyc;
        if (last_tail_cyc[o] >= 0) begin
          last_gap[o] = cyc - last_tail_cyc[o];
          check(last_gap[o] >= 2, "R11 gap after tail", last_gap[o], 2);
        end
        // R3: a misrouted header finds no matching entry in this output's queue
        compare(o, fl);
        mphase[o] = 1;
      end
    end else if (mphase[o] == 1) begin
      compare(o, fl);
      rem[o] = (int'(fl[7:0]) > 128) ? 128 : int'(fl[7:0]);
      last_len[o] = rem[o];
      if (rem[o] == 0) begin
        mphase[o] = 0;
        last_tail_cyc[o] = cyc;
      end else begin
        mphase[o] = 2;
      end
    end else begin
      compare(o, fl);
      rem[o]--;
      if (rem[o] == 0) begin
        mphase[o] = 0;
        last_tail_cyc[o] = cyc;
      end
    end
  endtask

  task automatic observe(input int o);
    if (held[o]) begin
      check(out_valid[o] && (out_flit[o] == held_flit[o]), "R9 stalled flit held",
            int'(out_flit[o]), int'(held_flit[o]));
    end
    held[o]      = out_valid[o] && !out_ready[o];
    held_flit[o] = out_flit[o];
    if (out_valid[o] && out_ready[o]) consume(o, out_flit[o]);
  endtask

  // input driver, source 0
  initial begin : drv_a
    bit took;
    took = 1'b0;
    v0 = 1'b0;
    f0 = '0;
    forever begin
      @(negedge clk);
      if (v0 && took) begin
        v0 = 1'b0;
        acc0++;
      end
      if (!v0 && srcq0.size() > 0 && rst_n) begin
        f0 = srcq0.pop_front();
        v0 = 1'b1;
        if (f0[8]) drv_hdr_cyc[0] = cyc;
      end
      took = in_ready[0];
    end
  end

  // input driver, source 1
  initial begin : drv_b
    bit took;
    took = 1'b0;
    v1 = 1'b0;
    f1 = '0;
    forever begin
      @(negedge clk);
      if (v1 && took) begin
        v1 = 1'b0;
        acc1++;
      end
      if (!v1 && srcq1.size() > 0 && rst_n) begin
        f1 = srcq1.pop_front();
        v1 = 1'b1;
        if (f1[8]) drv_hdr_cyc[1] = cyc;
      end
      took = in_ready[1];
    end
  end

  // downstream ready and output monitor
  initial begin : mon
    out_ready = 2'b11;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = stall ? 2'b00 : (bp ? lfsr[1:0] : 2'b11);
      #1;
      if (rst_n) begin
        for (int o = 0; o < 2; o++) observe(o);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", pending(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    int seq;
    seq = 0;
    rst_n = 1'b0;
    stall = 1'b0;
    bp = 1'b0;
    lfsr = 16'hACE1;
    acc0 = 0;
    acc1 = 0;
    for (int o = 0; o < 2; o++) begin
      mphase[o] = 0; cur[o] = 0; rem[o] = 0; out_hdr_cyc[o] = -1;
      last_tail_cyc[o] = -1; last_gap[o] = 0; last_len[o] = -1; held[o] = 1'b0;
      held_flit[o] = '0; drv_hdr_cyc[o] = -1;
    end
    repeat (3) @(negedge clk);
    // R1 during reset
    check(out_valid == 2'b00, "R1 out_valid in reset", int'(out_valid), 0);
    check(in_ready == 2'b11, "R1 in_ready in reset", int'(in_ready), 3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 after reset
    check(out_valid == 2'b00, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 2'b11, "R1 in_ready after reset", int'(in_ready), 3);

    // R10 header latency on an idle switch
    send(0, 1, 3, 1);
    drain();
    check(out_hdr_cyc[1] - drv_hdr_cyc[0] == 2, "R10 header latency",
          out_hdr_cyc[1] - drv_hdr_cyc[0], 2);

    // R7 parallel paths
    send(0, 0, 5, 2);
    send(1, 1, 5, 3);
    drain();
    check(out_hdr_cyc[0] == out_hdr_cyc[1], "R7 concurrent headers",
          out_hdr_cyc[1], out_hdr_cyc[0]);
    check(out_hdr_cyc[0] - drv_hdr_cyc[0] == 2, "R7 concurrent latency",
          out_hdr_cyc[0] - drv_hdr_cyc[0], 2);

    // R8 first contest on output 1: input 0 wins, input 1 follows
    hlog[1].delete();
    send(0, 1, 4, 4);
    send(1, 1, 4, 5);
    drain();
    check(hlog[1].size() == 2, "R8 two headers", hlog[1].size(), 2);
    if (hlog[1].size() == 2) begin
      check(hlog[1][0] == 0, "R8 first winner", hlog[1][0], 0);
      check(hlog[1][1] == 1, "R8 loser served next", hlog[1][1], 1);
    end
    // R11 waiting header follows the tail after exactly two edges
    check(last_gap[1] == 2, "R11 exact gap", last_gap[1], 2);

    // input 0 holds output 1 alone, so input 1 should win the next contest (R8)
    send(0, 1, 1, 6);
    drain();
    hlog[1].delete();
    send(0, 1, 2, 7);
    send(1, 1, 2, 8);
    drain();
    check(hlog[1].size() == 2, "R8 two headers again", hlog[1].size(), 2);
    if (hlog[1].size() == 2) begin
      check(hlog[1][0] == 1, "R8 rotated winner", hlog[1][0], 1);
      check(hlog[1][1] == 0, "R8 rotated loser", hlog[1][1], 0);
    end

    // R2 FIFO fills to 8 with the output blocked; R9 flit held meanwhile
    stall = 1'b1;
    acc0 = 0;
    send(0, 0, 20, 9);
    repeat (16) @(negedge clk);
    check(acc0 == 8, "R2 flits accepted while blocked", acc0, 8);
    check(in_ready[0] == 1'b0, "R2 in_ready low when full", int'(in_ready[0]), 0);
    check(out_valid[0] == 1'b1, "R9 blocked header offered", int'(out_valid[0]), 1);
    stall = 1'b0;
    drain();

    // R5 stray unmarked flits are discarded
    srcq0.push_back(9'h0AA);
    srcq0.push_back(9'h055);
    send(0, 1, 3, 10);
    drain();
    check(last_len[1] == 3, "R5 message after stray flits", last_len[1], 3);

    // R4 oversize count clamped
    send(1, 0, 200, 11);
    drain();
    check(last_len[0] == 128, "R4 count 200 clamped", last_len[0], 128);
    send(0, 1, 128, 12);
    drain();
    check(last_len[1] == 128, "R4 count 128 kept", last_len[1], 128);

    // sweep: every length 0..18, all source/route pairs, both back-pressure modes
    for (int len = 0; len <= 18; len++) begin
      bp = (len % 2) == 1;
      for (int r = 0; r < 2; r++) begin
        seq++;
        send(0, r, len, seq);
        seq++;
        send(1, 1 - r, len + 1, seq);
      end
      drain();
    end

    // long messages under random back-pressure, including clamp boundaries (R4)
    bp = 1'b1;
    for (int t = 0; t < 6; t++) begin
      int len;
      case (t)
        0: len = 63;
        1: len = 127;
        2: len = 128;
        3: len = 129;
        4: len = 255;
        default: len = 7;
      endcase
      for (int r = 0; r < 2; r++) begin
        seq++;
        send(0, r, len, seq);
        seq++;
        send(1, r, 255 - len, seq);
      end
      drain();
    end
    bp = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule